// File: doc/BRIEF.md
# Select-Controlled Adder/Subtractor ALU

A purely combinational arithmetic and logic unit for a 16-bit datapath. It takes two operands and a 3-bit operation code and returns a 16-bit result together with a carry-out. Addition, subtraction (A−B) and reverse subtraction (B−A) all use one shared adder. Before the adder, each operand passes through an XOR stage that inverts it when the relevant code bit is set. The carry-in comes from the code bits, so two's-complement subtraction completes in a single pass with no separate increment.

The adder is built from 4-bit carry-look-ahead groups. Each group exports a group generate and a group propagate. The carry into each group is formed from the previous group's generate and propagate, chained across the four groups. The logic and pass results are computed in parallel with the adder, and a final multiplexer picks the requested result. The block has no clock or state. It sits between operand buses and a destination bus.

Top module: `sel_alu`

## Requirements
- R1: Code 000 gives res = (A+B) mod 2^16, and cout is bit 16 of the unsigned sum.
- R2: Code 001 gives res = (A−B) mod 2^16, and cout is 1 exactly when A ≥ B as unsigned values.
- R3: Code 010 gives res = (B−A) mod 2^16, and cout is 1 exactly when B ≥ A as unsigned values.
- R4: The logic codes give bitwise results: 011 gives A AND B, 100 gives A OR B, and 101 gives A XOR B.
- R5: Code 110 gives res = A and code 111 gives res = B, each unchanged.
- R6: For every code from 011 to 111, cout is 0.
- R7: With A = 0x6F73 and B = 0x908D, where B is the two's-complement negation of A:
  - code 000 gives 0x0000 with cout 1;
  - code 011 gives 0x0001;
  - code 100 gives 0xFFFF;
  - code 101 gives 0xFFFE;
  - code 001 gives 0xDEE6 with cout 0;
  - code 010 gives 0x211A with cout 1.
- R8: A carry born in bit 0 travels through all four groups to the output. For example, 0xFFFF + 0x0001 gives 0x0000 with cout 1, and 0x8000 − 0x8000 gives 0x0000 with cout 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 16 | Operand A |
| opb_i | input | 16 | Operand B |
| sel_i | input | 3 | Operation code |
| res_o | output | 16 | Selected result |
| cout_o | output | 1 | Adder carry-out for arithmetic codes, 0 otherwise |

## Verification
The checks inside the design compare the outputs with a wide-integer reference only when the operands and the code are free of X and Z. This is because the block is combinational and its outputs mean nothing until the inputs settle. The bench keeps within this assumption in three ways:
- It drives every input from time zero.
- It changes the inputs only on the falling clock edge.
- It samples the outputs a quarter period later.

The bench covers every code with the fixed vector 0x6F73/0x908D, the edge operands 0, 0xFFFF and 0x8000, and seeded random operands.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'b000,
        OP_SUB   = 3'b001,
        OP_RSUB  = 3'b010,
        OP_AND   = 3'b011,
        OP_OR    = 3'b100,
        OP_XOR   = 3'b101,
        OP_PASSA = 3'b110,
        OP_PASSB = 3'b111
    } alu_op_e;

    // True for the three codes whose result comes from the adder.
    function automatic logic op_is_arith(input logic [2:0] code);
        return (code == OP_ADD) || (code == OP_SUB) || (code == OP_RSUB);
    endfunction

endpackage

// File: rtl/alu_opcond.sv
module alu_opcond #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             inv_a,
    input  logic             inv_b,
    output logic [WIDTH-1:0] xa,
    output logic [WIDTH-1:0] xb
);
    // Each operand bit is XORed with its own inversion control.
    assign xa = a ^ {WIDTH{inv_a}};
    assign xb = b ^ {WIDTH{inv_b}};
endmodule

// File: rtl/cla_group.sv
module cla_group #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] x,
    input  logic [GW-1:0] y,
    input  logic          cin,
    output logic [GW-1:0] sum,
    output logic          gg,
    output logic          gp
);
    logic [GW-1:0] p;
    logic [GW-1:0] g;
    logic [GW-1:0] c;

    assign p = x ^ y;
    assign g = x & y;

    // Every internal carry is expanded as a flat sum of products,
    // so no carry waits on the bit below it.
    always_comb begin
        c[0] = cin;
        for (int i = 1; i < GW; i++) begin
            logic acc;
            logic pp;
            acc = g[i-1];
            pp  = p[i-1];
            for (int j = i - 2; j >= 0; j--) begin
                acc = acc | (pp & g[j]);
                pp  = pp & p[j];
            end
            c[i] = acc | (pp & cin);
        end
    end

    // Group generate and propagate, independent of the carry-in.
    always_comb begin
        logic acc;
        logic pp;
        acc = g[GW-1];
        pp  = p[GW-1];
        for (int j = GW - 2; j >= 0; j--) begin
            acc = acc | (pp & g[j]);
            pp  = pp & p[j];
        end
        gg = acc;
        gp = &p;
    end

    assign sum = p ^ c;
endmodule

// File: rtl/alu_select.sv
module alu_select
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [2:0]       sel,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] sum,
    input  logic             carry,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    logic [WIDTH-1:0] r_and;
    logic [WIDTH-1:0] r_or;
    logic [WIDTH-1:0] r_xor;

    assign r_and = a & b;
    assign r_or  = a | b;
    assign r_xor = a ^ b;

    always_comb begin
        unique case (alu_op_e'(sel))
            OP_ADD, OP_SUB, OP_RSUB: res = sum;
            OP_AND:                  res = r_and;
            OP_OR:                   res = r_or;
            OP_XOR:                  res = r_xor;
            OP_PASSA:                res = a;
            OP_PASSB:                res = b;
            default:                 res = '0;
        endcase
    end

    assign cout = op_is_arith(sel) & carry;
endmodule

// File: rtl/sel_alu.sv
module sel_alu #(
    parameter int WIDTH = 16,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [2:0]       sel_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    localparam int NGROUP = WIDTH / GROUP;

    logic [WIDTH-1:0]  xa;
    logic [WIDTH-1:0]  xb;
    logic [WIDTH-1:0]  sum;
    logic [NGROUP:0]   gc;
    logic [NGROUP-1:0] gg;
    logic [NGROUP-1:0] gp;

    // Bit 1 of the code inverts A and bit 0 inverts B.
    alu_opcond #(.WIDTH(WIDTH)) u_cond (
        .a     (opa_i),
        .b     (opb_i),
        .inv_a (sel_i[1]),
        .inv_b (sel_i[0]),
        .xa    (xa),
        .xb    (xb)
    );

    // The two's-complement "+1" for either subtraction.
    assign gc[0] = sel_i[1] | sel_i[0];

    for (genvar k = 0; k < NGROUP; k++) begin : g_grp
        cla_group #(.GW(GROUP)) u_grp (
            .x   (xa[k*GROUP +: GROUP]),
            .y   (xb[k*GROUP +: GROUP]),
            .cin (gc[k]),
            .sum (sum[k*GROUP +: GROUP]),
            .gg  (gg[k]),
            .gp  (gp[k])
        );
        assign gc[k+1] = gg[k] | (gp[k] & gc[k]);
    end

    alu_select #(.WIDTH(WIDTH)) u_sel (
        .sel   (sel_i),
        .a     (opa_i),
        .b     (opb_i),
        .sum   (sum),
        .carry (gc[NGROUP]),
        .res   (res_o),
        .cout  (cout_o)
    );
endmodule

// File: rtl/sel_alu_chk.sv
module sel_alu_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic [2:0]       sel_i,
    input logic [WIDTH-1:0] res_o,
    input logic             cout_o
);
    logic [WIDTH:0] ref_add;
    logic [WIDTH:0] ref_sub;
    logic [WIDTH:0] ref_rsub;
    logic           known;

    assign ref_add  = {1'b0, opa_i} + {1'b0, opb_i};
    assign ref_sub  = {1'b0, opa_i} - {1'b0, opb_i};
    assign ref_rsub = {1'b0, opb_i} - {1'b0, opa_i};
    assign known    = !$isunknown({opa_i, opb_i, sel_i});

    always_comb begin
        if (known && sel_i == 3'b000) begin
            AST_ADD_SUM: assert ({cout_o, res_o} == ref_add); // R1
        end
        if (known && sel_i == 3'b001) begin
            AST_SUB_DIFF: assert (res_o == ref_sub[WIDTH-1:0] && cout_o == (opa_i >= opb_i)); // R2
        end
        if (known && sel_i == 3'b010) begin
            AST_RSUB_DIFF: assert (res_o == ref_rsub[WIDTH-1:0] && cout_o == (opb_i >= opa_i)); // R3
        end
        if (known && sel_i == 3'b101) begin
            AST_XOR_BITS: assert ((res_o ^ opb_i) == opa_i); // R4
        end
        if (known && sel_i == 3'b110) begin
            AST_PASS_A: assert (res_o == opa_i); // R5
        end
        if (known && sel_i == 3'b111) begin
            AST_PASS_B: assert (res_o == opb_i); // R5
        end
        if (known && sel_i >= 3'b011) begin
            AST_NO_CARRY_LOGIC: assert (cout_o == 1'b0); // R6
        end
    end
endmodule

bind sel_alu sel_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .sel_i  (sel_i),
    .res_o  (res_o),
    .cout_o (cout_o)
);

// File: tb/sim_sel_alu.sv
module sim_sel_alu;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a   = '0;
    logic [W-1:0] b   = '0;
    logic [2:0]   sel = 3'b000;
    logic [W-1:0] res;
    logic         cout;
    int           n_chk  = 0;
    int           n_fail = 0;
    logic         done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sel_alu u0 (
        .opa_i  (a),
        .opb_i  (b),
        .sel_i  (sel),
        .res_o  (res),
        .cout_o (cout)
    );

    // Reference model written from the requirements: {carry, result}.
    function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic [2:0] op);
        logic [W:0] r;
        case (op)
            3'd0: r = {1'b0, x} + {1'b0, y};
            3'd1: r = {(x >= y), x - y};
            3'd2: r = {(y >= x), y - x};
            3'd3: r = {1'b0, x & y};
            3'd4: r = {1'b0, x | y};
            3'd5: r = {1'b0, x ^ y};
            3'd6: r = {1'b0, x};
            default: r = {1'b0, y};
        endcase
        return r;
    endfunction

    function automatic string res_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3, 3'd4, 3'd5: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // Drive on the falling edge, sample a quarter period later.
    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] op);
        @(negedge clk);
        a = x; b = y; sel = op;
        #(CLK_PERIOD/4);
    endtask

    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] op);
        logic [W:0] e;
        apply(x, y, op);
        e = model(x, y, op);
        check(res_tag(op), "result", res, e[W-1:0]);
        check((op >= 3'd3) ? "R6" : res_tag(op), "carry", {15'd0, cout}, {15'd0, e[W]});
    endtask

    task automatic t_reset_state;
        apply('0, '0, 3'b000);
        check("R1", "zero inputs result", res, 16'h0000);
        check("R1", "zero inputs carry", {15'd0, cout}, 16'h0000);
    endtask

    task automatic t_vector;
        apply(16'h6F73, 16'h908D, 3'd0);
        check("R7", "add", {cout, res[14:0]}, {1'b1, 15'h0000});
        check("R7", "add msb", {15'd0, res[15]}, 16'h0000);
        apply(16'h6F73, 16'h908D, 3'd3);
        check("R7", "and", res, 16'h0001);
        apply(16'h6F73, 16'h908D, 3'd4);
        check("R7", "or", res, 16'hFFFF);
        apply(16'h6F73, 16'h908D, 3'd5);
        check("R7", "xor", res, 16'hFFFE);
        apply(16'h6F73, 16'h908D, 3'd1);
        check("R7", "sub", res, 16'hDEE6);
        check("R7", "sub carry", {15'd0, cout}, 16'h0000);
        apply(16'h6F73, 16'h908D, 3'd2);
        check("R7", "rsub", res, 16'h211A);
        check("R7", "rsub carry", {15'd0, cout}, 16'h0001);
    endtask

    task automatic t_carry_chain;
        apply(16'hFFFF, 16'h0001, 3'd0);
        check("R8", "ffff+1", res, 16'h0000);
        check("R8", "ffff+1 carry", {15'd0, cout}, 16'h0001);
        apply(16'h8000, 16'h8000, 3'd1);
        check("R8", "8000-8000", res, 16'h0000);
        check("R8", "8000-8000 carry", {15'd0, cout}, 16'h0001);
        apply(16'h0001, 16'hFFFF, 3'd2);
        check("R8", "ffff-1", res, 16'hFFFE);
        check("R8", "ffff-1 carry", {15'd0, cout}, 16'h0001);
    endtask

    task automatic t_edges;
        logic [W-1:0] edge_v [3] = '{16'h0000, 16'hFFFF, 16'h8000};
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
                for (int op = 0; op < 8; op++)
                    run_op(edge_v[i], edge_v[j], op[2:0]);
    endtask

    task automatic t_random;
        logic [W-1:0] x;
        logic [W-1:0] y;
        for (int n = 0; n < 400; n++) begin
            x = W'($urandom());
            y = W'($urandom());
            run_op(x, y, n[2:0]);
        end
    endtask

    initial begin
        void'($urandom(32'd7));
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_vector();
        t_carry_chain();
        t_edges();
        t_random();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule